// File: doc/BRIEF.md
# Display Refresh Fetch Address Generator

This block produces the memory address for each display-refresh fetch in a character-mode video controller. A 16-bit scan counter is preset once per frame from a programmable start address and then advances by one on every character-clock enable. Software scrolls the picture by rewriting the start address. The address is written as two bytes, high and low. Each byte goes first to a holding register and is copied into the counter only when the next frame begins.

Every fetch reads two display planes at the same plane-relative address. Plane 0 returns the character code and plane 1 returns its attribute. In byte addressing the address is the counter value, so the whole 64K range is read in order and wraps cleanly to zero. In word addressing the counter is rotated left by one bit, and its top bit lands in address bit 0. Below half range this gives only even addresses. Once the counter reaches 0x8000 the fetches move to odd addresses and do not wrap back to the even ones.

Top module: `disp_fetch_addr_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, fetch_valid is 0, fetch_addr is 0x0000 and plane_rd is 2'b00. The counter and both start-address bytes reset to zero.
- R2: A write to the high or low start-address byte changes nothing in the current frame. Fetches issued after the write continue in sequence from the old count.
- R3: A frame_start pulse loads the counter with {high byte, low byte}. The first fetch after it addresses that start value.
- R4: Each cycle with char_en high and frame_start low issues one fetch. On the next cycle fetch_valid is 1 and fetch_addr reflects the count before the step, and the counter then advances by one.
- R5: With word_mode=0 (byte addressing), fetch_addr equals the counter. After count 0xFFFF the next fetch is at 0x0000.
- R6: With word_mode=1 (word addressing), fetch_addr = {count[14:0], count[15]}. Count 0x7FFF fetches 0xFFFE, and count 0x8000 fetches 0x0001.
- R7: When frame_start and char_en are high in the same cycle, the reload wins. No fetch is issued (fetch_valid is 0 on the next cycle), and the next fetch is at the start address.
- R8: plane_rd is 2'b11 (bit 0 = character plane 0, bit 1 = attribute plane 1) exactly when fetch_valid is 1, and 2'b00 otherwise. Without char_en the counter holds its value.
- R9: A byte write in the same cycle as frame_start is not seen by that load. The load uses the byte value held before that cycle, and the new value takes effect at the following frame_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_hi_we | input | 1 | Write strobe for the high start-address byte |
| start_lo_we | input | 1 | Write strobe for the low start-address byte |
| start_wdata | input | 8 | Byte written by either strobe |
| frame_start | input | 1 | Frame-start strobe that reloads the counter |
| char_en | input | 1 | Character-clock enable, one fetch per pulse |
| word_mode | input | 1 | 0 = byte addressing, 1 = word addressing |
| fetch_addr | output | 16 | Plane-relative byte address of the fetch |
| fetch_valid | output | 1 | A fetch is issued this cycle |
| plane_rd | output | 2 | Plane read selects: bit 0 character, bit 1 attribute |

## Verification
The hardest cases sit at the ends of the 16-bit count. These are the byte-mode rollover from 0xFFFF to 0x0000 and the word-mode jump from even to odd addresses at 0x8000. Stepping there one fetch at a time would take tens of thousands of cycles. The stimulus instead writes a start address a few counts below each boundary, pulses frame_start and steps across it. The same-cycle collisions of reload with step and of reload with register write are also covered, each by driving both strobes on one clock edge.

// File: rtl/disp_addr_pkg.sv
package disp_addr_pkg;
  typedef enum logic {
    ADDR_BYTE = 1'b0,
    ADDR_WORD = 1'b1
  } addr_mode_e;

  localparam int PLANE_CNT = 2;
endpackage

// File: rtl/start_addr_regs.sv
module start_addr_regs #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  localparam int NBYTES = ADDR_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NBYTES-1:0] byte_we,
  input  logic [BYTE_W-1:0] wdata,
  output logic [ADDR_W-1:0] start_q
);
  // Holding bytes; only read by the counter at frame start.
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst) begin
        start_q[b*BYTE_W +: BYTE_W] <= '0;
      end else if (byte_we[b]) begin
        start_q[b*BYTE_W +: BYTE_W] <= wdata;
      end
    end
  end
endmodule

// File: rtl/scan_counter.sv
module scan_counter #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] load_val,
  output logic [ADDR_W-1:0] count_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (load) begin
      count_q <= load_val;
    end else if (step) begin
      count_q <= count_q + 1'b1;
    end
  end
endmodule

// File: rtl/fetch_addr_map.sv
module fetch_addr_map
  import disp_addr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 issue,
  input  addr_mode_e           mode,
  input  logic [ADDR_W-1:0]    count,
  output logic [ADDR_W-1:0]    addr_q,
  output logic                 valid_q,
  output logic [PLANE_CNT-1:0] planes_q
);
  logic [ADDR_W-1:0] rot;

  // Word addressing: rotate the count left by one bit.
  for (genvar i = 0; i < ADDR_W; i++) begin : g_rot
    if (i == 0) begin : g_lsb
      assign rot[i] = count[ADDR_W-1];
    end else begin : g_up
      assign rot[i] = count[i-1];
    end
  end

  logic [ADDR_W-1:0] addr_d;
  always_comb begin
    unique case (mode)
      ADDR_WORD: addr_d = rot;
      default:   addr_d = count;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      valid_q  <= 1'b0;
      planes_q <= '0;
    end else begin
      valid_q  <= issue;
      planes_q <= {PLANE_CNT{issue}};
      if (issue) begin
        addr_q <= addr_d;
      end
    end
  end
endmodule

// File: rtl/disp_fetch_addr_gen.sv
module disp_fetch_addr_gen
  import disp_addr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_hi_we,
  input  logic              start_lo_we,
  input  logic [BYTE_W-1:0] start_wdata,
  input  logic              frame_start,
  input  logic              char_en,
  input  logic              word_mode,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_valid,
  output logic [1:0]        plane_rd
);
  logic [ADDR_W-1:0] start_q;
  logic [ADDR_W-1:0] ctr_q;
  logic              issue;

  // Reload takes priority over a step in the same cycle.
  assign issue = char_en & ~frame_start;

  start_addr_regs #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .byte_we ({start_hi_we, start_lo_we}),
    .wdata   (start_wdata),
    .start_q (start_q)
  );

  scan_counter #(.ADDR_W(ADDR_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load     (frame_start),
    .step     (issue),
    .load_val (start_q),
    .count_q  (ctr_q)
  );

  fetch_addr_map #(.ADDR_W(ADDR_W)) u_map (
    .clk      (clk),
    .rst      (rst),
    .issue    (issue),
    .mode     (addr_mode_e'(word_mode)),
    .count    (ctr_q),
    .addr_q   (fetch_addr),
    .valid_q  (fetch_valid),
    .planes_q (plane_rd)
  );
endmodule

// File: rtl/disp_fetch_addr_chk.sv
module disp_fetch_addr_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_start,
  input logic              char_en,
  input logic              word_mode,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              fetch_valid,
  input logic [1:0]        plane_rd,
  input logic [ADDR_W-1:0] ctr_q,
  input logic [ADDR_W-1:0] start_q
);
  a_r8_planes_on: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |-> plane_rd == 2'b11);
  a_r8_planes_off: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |-> plane_rd == 2'b00);
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!frame_start && !char_en) |=> $stable(ctr_q));
  a_r7_reload_wins: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !fetch_valid);
  a_r3_load: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> ctr_q == $past(start_q));
  a_r4_issue: assert property (@(posedge clk) disable iff (rst)
    (char_en && !frame_start) |=> fetch_valid && ctr_q == $past(ctr_q) + 1'b1);
  a_r5_byte_addr: assert property (@(posedge clk) disable iff (rst)
    (char_en && !frame_start && !word_mode) |=> fetch_addr == $past(ctr_q));
  a_r6_word_odd: assert property (@(posedge clk) disable iff (rst)
    (char_en && !frame_start && word_mode) |=> fetch_addr[0] == $past(ctr_q[ADDR_W-1]));
endmodule

bind disp_fetch_addr_gen disp_fetch_addr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .frame_start (frame_start),
  .char_en     (char_en),
  .word_mode   (word_mode),
  .fetch_addr  (fetch_addr),
  .fetch_valid (fetch_valid),
  .plane_rd    (plane_rd),
  .ctr_q       (ctr_q),
  .start_q     (start_q)
);

// File: tb/disp_fetch_addr_gen_bench.sv
`timescale 1ns/1ps
module disp_fetch_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_hi_we = 1'b0;
  logic        start_lo_we = 1'b0;
  logic [7:0]  start_wdata = '0;
  logic        frame_start = 1'b0;
  logic        char_en = 1'b0;
  logic        word_mode = 1'b0;
  logic [15:0] fetch_addr;
  logic        fetch_valid;
  logic [1:0]  plane_rd;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  disp_fetch_addr_gen u_disp_fetch_addr_gen (
    .clk, .rst, .start_hi_we, .start_lo_we, .start_wdata,
    .frame_start, .char_en, .word_mode,
    .fetch_addr, .fetch_valid, .plane_rd
  );

  task automatic check(string req, logic [18:0] act, logic [18:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual valid/planes/addr=%h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_start(logic [15:0] v);
    start_hi_we = 1'b1; start_wdata = v[15:8]; tick();
    start_hi_we = 1'b0;
    start_lo_we = 1'b1; start_wdata = v[7:0];  tick();
    start_lo_we = 1'b0;
  endtask

  task automatic frame();
    frame_start = 1'b1; tick(); frame_start = 1'b0;
  endtask

  task automatic step_expect(string req, logic [15:0] exp);
    char_en = 1'b1; tick(); char_en = 1'b0;
    check(req, {fetch_valid, plane_rd, fetch_addr}, {1'b1, 2'b11, exp});
  endtask

  task automatic t_reset();
    check("R1", {fetch_valid, plane_rd, fetch_addr}, 19'h0);
    step_expect("R1 counter zero", 16'h0000);
  endtask

  task automatic t_load_and_step();
    word_mode = 1'b0;
    write_start(16'h1234);
    step_expect("R2 write not applied", 16'h0001);
    frame();
    step_expect("R3", 16'h1234);
    step_expect("R4", 16'h1235);
    step_expect("R4", 16'h1236);
  endtask

  task automatic t_midframe_write();
    write_start(16'hABCD);
    step_expect("R2", 16'h1237);
    frame();
    step_expect("R3 new start", 16'hABCD);
  endtask

  task automatic t_byte_wrap();
    word_mode = 1'b0;
    write_start(16'hFFFE);
    frame();
    step_expect("R5", 16'hFFFE);
    step_expect("R5", 16'hFFFF);
    step_expect("R5 wrap", 16'h0000);
    step_expect("R5", 16'h0001);
  endtask

  task automatic t_word_mode();
    word_mode = 1'b1;
    write_start(16'h0003);
    frame();
    step_expect("R6 even", 16'h0006);
    step_expect("R6 even", 16'h0008);
    write_start(16'h7FFE);
    frame();
    step_expect("R6", 16'hFFFC);
    step_expect("R6", 16'hFFFE);
    step_expect("R6 odd jump", 16'h0001);
    step_expect("R6 odd", 16'h0003);
    word_mode = 1'b0;
  endtask

  task automatic t_reload_wins();
    write_start(16'h1000);
    frame();
    step_expect("R7 pre", 16'h1000);
    step_expect("R7 pre", 16'h1001);
    frame_start = 1'b1; char_en = 1'b1; tick();
    frame_start = 1'b0; char_en = 1'b0;
    check("R7 no fetch", {fetch_valid, plane_rd, 16'h0}, 19'h0);
    step_expect("R7 restart", 16'h1000);
  endtask

  task automatic t_idle();
    tick(); tick();
    check("R8 idle", {fetch_valid, plane_rd, 16'h0}, 19'h0);
    step_expect("R8 held", 16'h1001);
  endtask

  task automatic t_write_during_load();
    write_start(16'h1020);
    start_hi_we = 1'b1; start_wdata = 8'h55; frame_start = 1'b1; tick();
    start_hi_we = 1'b0; frame_start = 1'b0;
    step_expect("R9 old byte", 16'h1020);
    frame();
    step_expect("R9 new byte", 16'h5520);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", {fetch_valid, plane_rd, fetch_addr}, 19'h0);
    rst = 1'b0;
    t_reset();
    t_load_and_step();
    t_midframe_write();
    t_byte_wrap();
    t_word_mode();
    t_reload_wins();
    t_idle();
    t_write_during_load();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule